// File: doc/BRIEF.md
# Flash Erase-Block Write-Protection Gate

This block sits between a NOR-style flash command decoder and the array write engine. Each erase block has two protection flags: a lock flag and a lock-down flag. Every write-class request (program, erase, one-time-programmable write, or a change to the lock flags) is checked here. The request carries a block index and an operation code. The block weighs it against the write-protect pin (`wp_n`), the two supply-lockout senses, the functional reset (`rst_n`) and the stored flags. One cycle later it answers with either a grant pulse or a deny pulse.

Unlocking has two tiers. A block with its lock-down flag set refuses to have its lock flag cleared while `wp_n` is low. Once `wp_n` is high, lock-down has no effect. The lock-down flag can be set only by command and is cleared only by reset. A sticky error flag records any refusal until `err_clr` is pulsed. A combinational query port returns the two flags of any block.

The controller is a four-state machine:
- `ST_HELD`: reset asserted and no request.
- `ST_READY`: array-read mode, idle.
- `ST_GRANT`: one-cycle grant.
- `ST_DENY`: one-cycle deny.

Transitions, evaluated at every clock edge:
- A request moves the machine to `ST_GRANT` when allowed and to `ST_DENY` when refused. This holds from any state.
- With no request, the machine goes to `ST_READY` if `rst_n` is high and to `ST_HELD` if it is low.

Top module: `flash_lock_guard`

## Requirements
- R1: While `rst_n` is low (sampled at a clock edge), every request is refused. Every lock flag is set, every lock-down flag is cleared, and `read_mode` is 0.
- R2: `read_mode` becomes 1 one cycle after the first edge at which `rst_n` is sampled high, with neither `grant` nor `deny` active.
- R3: Ops 0 (program), 1 (buffered program) and 2 (block erase) are refused on a block whose lock flag is set, whatever the level of `wp_n`. They are granted on a block whose lock flag is clear.
- R4: Op 6 (clear lock) on a block with its lock-down flag set is refused while `wp_n` is low, and the lock flag stays set.
- R5: While `wp_n` is high, op 6 is granted on any block, including one with lock-down set. Its lock flag clears and its lock-down flag stays set.
- R6: While `vpp_low` is 1, ops 0 to 4 are refused (op 3 = full-chip erase, op 4 = one-time-programmable write). Ops 5 and 6 are still granted.
- R7: While `vcc_low` is 1, every request (ops 0 to 7) is refused and no flag changes.
- R8: Op 7 (lock-down) is granted and sets both flags of the block. A lock-down flag stays set until reset.
- R9: The answer to a request sampled at edge N appears on `grant` or `deny` for exactly the cycle after edge N. A refusal sets `err_flag`. `err_flag` holds until `err_clr` is sampled high with no refusal at the same edge; a refusal at that same edge wins.
- R10: Op 3 is granted only when no block's lock flag is set.
- R11: `qry_locked` and `qry_lockdown` follow `qry_blk` combinationally, without waiting for a clock edge.
- R12: Op 5 (set lock) is granted and sets the addressed block's lock flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Functional reset, active low, sampled synchronously |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 3 | Operation code (0 to 7, see requirements) |
| req_blk | input | IDXW | Target erase block |
| wp_n | input | 1 | Write-protect pin, low = protect lock-down blocks |
| vpp_low | input | 1 | Programming voltage below lockout |
| vcc_low | input | 1 | Supply voltage below lockout |
| err_clr | input | 1 | Clears the sticky error flag |
| qry_blk | input | IDXW | Block index for the status query |
| grant | output | 1 | One-cycle grant pulse |
| deny | output | 1 | One-cycle deny pulse |
| read_mode | output | 1 | Array-read mode active |
| err_flag | output | 1 | Sticky refusal flag |
| qry_locked | output | 1 | Lock flag of `qry_blk` |
| qry_lockdown | output | 1 | Lock-down flag of `qry_blk` |

## Verification
Array-write requests are issued against blocks that are unlocked, locked, and locked-down-then-unlocked, with `wp_n` at both levels; this separates the lock-flag check from the lock-down check. The same program and lock-change ops are repeated under each supply lockout. This shows that the programming-voltage sense blocks only array writes, while the supply sense blocks everything. Full-chip erase is tried with one block locked and then with all blocks unlocked. A refusal coinciding with `err_clr` shows which of the two wins on the error flag.

// File: rtl/flash_lock_pkg.sv
package flash_lock_pkg;

    typedef enum logic [2:0] {
        OP_PROG      = 3'd0,
        OP_BUFPROG   = 3'd1,
        OP_BLKERASE  = 3'd2,
        OP_CHIPERASE = 3'd3,
        OP_OTP       = 3'd4,
        OP_LOCK      = 3'd5,
        OP_UNLOCK    = 3'd6,
        OP_LOCKDOWN  = 3'd7
    } wr_op_e;

    typedef enum logic [1:0] {
        ST_HELD  = 2'd0,
        ST_READY = 2'd1,
        ST_GRANT = 2'd2,
        ST_DENY  = 2'd3
    } gate_state_e;

    // Operations that need the programming voltage
    function automatic logic needs_vpp(wr_op_e op);
        return (op == OP_PROG) || (op == OP_BUFPROG) || (op == OP_BLKERASE) ||
               (op == OP_CHIPERASE) || (op == OP_OTP);
    endfunction

    // Operations refused on a locked target block
    function automatic logic blocked_by_lock(wr_op_e op);
        return (op == OP_PROG) || (op == OP_BUFPROG) || (op == OP_BLKERASE);
    endfunction

endpackage

// File: rtl/lock_bank.sv
module lock_bank
    import flash_lock_pkg::*;
#(
    parameter int NBLK = 8,
    parameter int IDXW = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            set_lock,
    input  logic            clr_lock,
    input  logic            set_ldown,
    input  logic [IDXW-1:0] wr_blk,
    input  logic [IDXW-1:0] qry_blk,
    output logic            rd_locked,
    output logic            rd_ldown,
    output logic            qry_locked,
    output logic            qry_ldown,
    output logic            any_locked
);

    logic [NBLK-1:0] lk;
    logic [NBLK-1:0] ld;

    for (genvar g = 0; g < NBLK; g++) begin : g_blk
        logic lk_r;
        logic ld_r;
        logic hit;

        assign hit = (wr_blk == IDXW'(g));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lk_r <= 1'b1;
                ld_r <= 1'b0;
            end else if (hit) begin
                if (set_lock || set_ldown) begin
                    lk_r <= 1'b1;
                end else if (clr_lock) begin
                    lk_r <= 1'b0;
                end
                if (set_ldown) begin
                    ld_r <= 1'b1;
                end
            end
        end

        assign lk[g] = lk_r;
        assign ld[g] = ld_r;

        AST_LDOWN_PERSISTS: assert property (@(posedge clk) disable iff (!rst_n)
            ld_r |=> ld_r);  // R8

        AST_LDOWN_SET_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
            (hit && set_ldown) |=> (lk_r && ld_r));  // R8
    end

    assign rd_locked  = lk[wr_blk];
    assign rd_ldown   = ld[wr_blk];
    assign qry_locked = lk[qry_blk];
    assign qry_ldown  = ld[qry_blk];
    assign any_locked = |lk;

endmodule

// File: rtl/gate_policy.sv
module gate_policy
    import flash_lock_pkg::*;
(
    input  wr_op_e op,
    input  logic   rst_n,
    input  logic   wp_n,
    input  logic   vpp_low,
    input  logic   vcc_low,
    input  logic   tgt_locked,
    input  logic   tgt_ldown,
    input  logic   any_locked,
    output logic   allow
);

    logic op_ok;

    always_comb begin
        unique case (op)
            OP_PROG, OP_BUFPROG, OP_BLKERASE: op_ok = !tgt_locked;
            OP_CHIPERASE:                     op_ok = !any_locked;
            OP_OTP:                           op_ok = 1'b1;
            OP_LOCK, OP_LOCKDOWN:             op_ok = 1'b1;
            OP_UNLOCK:                        op_ok = !(tgt_ldown && !wp_n);
            default:                          op_ok = 1'b0;
        endcase
    end

    assign allow = rst_n && !vcc_low && !(vpp_low && needs_vpp(op)) && op_ok;

endmodule

// File: rtl/flash_lock_guard.sv
module flash_lock_guard
    import flash_lock_pkg::*;
#(
    parameter int NBLK = 8,
    localparam int IDXW = (NBLK > 1) ? $clog2(NBLK) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic [2:0]      req_op,
    input  logic [IDXW-1:0] req_blk,
    input  logic            wp_n,
    input  logic            vpp_low,
    input  logic            vcc_low,
    input  logic            err_clr,
    input  logic [IDXW-1:0] qry_blk,
    output logic            grant,
    output logic            deny,
    output logic            read_mode,
    output logic            err_flag,
    output logic            qry_locked,
    output logic            qry_lockdown
);

    wr_op_e      op;
    gate_state_e state, nxt;
    logic        allow, accept, refuse;
    logic        tgt_locked, tgt_ldown, any_locked;

    assign op     = wr_op_e'(req_op);
    assign accept = req_valid && allow;
    assign refuse = req_valid && !allow;

    lock_bank #(.NBLK(NBLK), .IDXW(IDXW)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_lock   (accept && (op == OP_LOCK)),
        .clr_lock   (accept && (op == OP_UNLOCK)),
        .set_ldown  (accept && (op == OP_LOCKDOWN)),
        .wr_blk     (req_blk),
        .qry_blk    (qry_blk),
        .rd_locked  (tgt_locked),
        .rd_ldown   (tgt_ldown),
        .qry_locked (qry_locked),
        .qry_ldown  (qry_lockdown),
        .any_locked (any_locked)
    );

    gate_policy u_policy (
        .op         (op),
        .rst_n      (rst_n),
        .wp_n       (wp_n),
        .vpp_low    (vpp_low),
        .vcc_low    (vcc_low),
        .tgt_locked (tgt_locked),
        .tgt_ldown  (tgt_ldown),
        .any_locked (any_locked),
        .allow      (allow)
    );

    // Next-state logic
    always_comb begin
        unique case (state)
            ST_HELD, ST_READY, ST_GRANT, ST_DENY: begin
                if (req_valid)  nxt = allow ? ST_GRANT : ST_DENY;
                else if (rst_n) nxt = ST_READY;
                else            nxt = ST_HELD;
            end
            default: nxt = ST_HELD;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        state <= nxt;
    end

    // Registered outputs
    always_ff @(posedge clk) begin
        read_mode <= rst_n;
        if (!rst_n) err_flag <= refuse;
        else        err_flag <= (err_flag && !err_clr) || refuse;
    end

    assign grant = (state == ST_GRANT);
    assign deny  = (state == ST_DENY);

    AST_DENY_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        deny |-> err_flag);  // R9

    AST_NO_REQ_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!grant && !deny));  // R9

    AST_ERR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (err_clr && !req_valid) |=> !err_flag);  // R9

    AST_VCC_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && vcc_low) |=> deny);  // R7

    AST_VPP_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && vpp_low && needs_vpp(op)) |=> deny);  // R6

    AST_LOCKED_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && blocked_by_lock(op) && tgt_locked) |=> deny);  // R3

    AST_LDOWN_UNLOCK_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (op == OP_UNLOCK) && tgt_ldown && !wp_n) |=> deny);  // R4

    AST_CHIP_ERASE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (op == OP_CHIPERASE) && any_locked) |=> deny);  // R10

endmodule

// File: tb/test_flash_lock_guard.sv
module test_flash_lock_guard;

    localparam logic [2:0] PROG = 3'd0, BUFPROG = 3'd1, BLKERASE = 3'd2, CHIPERASE = 3'd3,
                           OTP = 3'd4, LOCK = 3'd5, UNLOCK = 3'd6, LOCKDOWN = 3'd7;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [2:0] req_op = 3'd0;
    logic [2:0] req_blk = 3'd0;
    logic       wp_n = 1'b0;
    logic       vpp_low = 1'b0;
    logic       vcc_low = 1'b0;
    logic       err_clr = 1'b0;
    logic [2:0] qry_blk = 3'd0;
    logic       grant, deny, read_mode, err_flag, qry_locked, qry_lockdown;

    int n_run = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    flash_lock_guard #(.NBLK(8)) i_flash_lock_guard (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_blk(req_blk), .wp_n(wp_n), .vpp_low(vpp_low), .vcc_low(vcc_low),
        .err_clr(err_clr), .qry_blk(qry_blk), .grant(grant), .deny(deny),
        .read_mode(read_mode), .err_flag(err_flag), .qry_locked(qry_locked),
        .qry_lockdown(qry_lockdown)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Issue one request; return at the negedge after the sampling edge
    task automatic do_req(input logic [2:0] op, input logic [2:0] blk);
        @(negedge clk);
        req_valid = 1'b1;
        req_op    = op;
        req_blk   = blk;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic expect_answer(input string tag, input logic ok);
        chk({tag, " grant"}, grant, ok);
        chk({tag, " deny"},  deny,  !ok);
    endtask

    task automatic query(input logic [2:0] b, input logic lk, input logic ld, input string tag);
        qry_blk = b;
        #1;
        chk({tag, " locked"},   qry_locked,   lk);
        chk({tag, " lockdown"}, qry_lockdown, ld);
    endtask

    task automatic t_reset_state;
        repeat (3) @(negedge clk);
        chk("R1 read_mode in reset", read_mode, 1'b0);
        for (int b = 0; b < 8; b++) query(3'(b), 1'b1, 1'b0, "R1 reset flags");
        do_req(UNLOCK, 3'd1);
        expect_answer("R1 request in reset", 1'b0);
        chk("R9 err after reset refusal", err_flag, 1'b1);
        query(3'd1, 1'b1, 1'b0, "R1 unlock ignored in reset");
        rst_n = 1'b1;
        @(negedge clk);
        chk("R2 read_mode after release", read_mode, 1'b1);
        chk("R2 no grant", grant, 1'b0);
        chk("R2 no deny", deny, 1'b0);
    endtask

    task automatic t_err_clear;
        err_clr = 1'b1;
        @(negedge clk);
        err_clr = 1'b0;
        chk("R9 err cleared", err_flag, 1'b0);
    endtask

    task automatic t_lock_program;
        do_req(UNLOCK, 3'd2);
        expect_answer("R5 plain unlock", 1'b1);
        query(3'd2, 1'b0, 1'b0, "R5 block2 unlocked");
        do_req(PROG, 3'd2);
        expect_answer("R3 program unlocked", 1'b1);
        do_req(BLKERASE, 3'd3);
        expect_answer("R3 erase locked wp low", 1'b0);
        wp_n = 1'b1;
        do_req(BUFPROG, 3'd3);
        expect_answer("R3 bufprog locked wp high", 1'b0);
        @(negedge clk);
        chk("R9 deny one cycle", deny, 1'b0);
        chk("R9 err set", err_flag, 1'b1);
        wp_n = 1'b0;
        do_req(LOCK, 3'd2);
        expect_answer("R12 lock", 1'b1);
        query(3'd2, 1'b1, 1'b0, "R12 block2 locked");
        do_req(UNLOCK, 3'd2);
        expect_answer("R12 re-unlock", 1'b1);
    endtask

    task automatic t_lockdown;
        do_req(LOCKDOWN, 3'd4);
        expect_answer("R8 lockdown", 1'b1);
        query(3'd4, 1'b1, 1'b1, "R8 block4 flags");
        do_req(UNLOCK, 3'd4);
        expect_answer("R4 unlock lockdown wp low", 1'b0);
        query(3'd4, 1'b1, 1'b1, "R4 block4 unchanged");
        wp_n = 1'b1;
        do_req(UNLOCK, 3'd4);
        expect_answer("R5 unlock lockdown wp high", 1'b1);
        query(3'd4, 1'b0, 1'b1, "R5 block4 after unlock");
        wp_n = 1'b0;
        do_req(PROG, 3'd4);
        expect_answer("R3 program after unlock", 1'b1);
    endtask

    task automatic t_query;
        @(negedge clk);
        query(3'd4, 1'b0, 1'b1, "R11 query blk4");
        query(3'd3, 1'b1, 1'b0, "R11 query blk3");
    endtask

    task automatic t_vpp;
        vpp_low = 1'b1;
        do_req(PROG, 3'd2);
        expect_answer("R6 program vpp low", 1'b0);
        do_req(OTP, 3'd0);
        expect_answer("R6 otp vpp low", 1'b0);
        do_req(LOCK, 3'd2);
        expect_answer("R6 lock vpp low", 1'b1);
        do_req(UNLOCK, 3'd2);
        expect_answer("R6 unlock vpp low", 1'b1);
        vpp_low = 1'b0;
    endtask

    task automatic t_vcc;
        vcc_low = 1'b1;
        do_req(PROG, 3'd2);
        expect_answer("R7 program vcc low", 1'b0);
        do_req(UNLOCK, 3'd6);
        expect_answer("R7 unlock vcc low", 1'b0);
        query(3'd6, 1'b1, 1'b0, "R7 block6 unchanged");
        do_req(LOCKDOWN, 3'd2);
        expect_answer("R7 lockdown vcc low", 1'b0);
        query(3'd2, 1'b0, 1'b0, "R7 block2 unchanged");
        vcc_low = 1'b0;
    endtask

    task automatic t_err_race;
        vcc_low = 1'b1;
        @(negedge clk);
        err_clr   = 1'b1;
        req_valid = 1'b1;
        req_op    = LOCK;
        req_blk   = 3'd0;
        @(negedge clk);
        req_valid = 1'b0;
        err_clr   = 1'b0;
        vcc_low   = 1'b0;
        chk("R9 refusal beats clear", err_flag, 1'b1);
        t_err_clear();
    endtask

    task automatic t_chip_erase;
        do_req(CHIPERASE, 3'd0);
        expect_answer("R10 chip erase with locks", 1'b0);
        wp_n = 1'b1;
        for (int b = 0; b < 8; b++) do_req(UNLOCK, 3'(b));
        wp_n = 1'b0;
        do_req(CHIPERASE, 3'd5);
        expect_answer("R10 chip erase all unlocked", 1'b1);
    endtask

    task automatic t_reset_again;
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1 read_mode low again", read_mode, 1'b0);
        query(3'd4, 1'b1, 1'b0, "R8 reset clears lockdown");
        query(3'd2, 1'b1, 1'b0, "R1 reset relocks");
        rst_n = 1'b1;
        @(negedge clk);
        chk("R2 read_mode again", read_mode, 1'b1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        t_reset_state();
        t_err_clear();
        t_lock_program();
        t_lockdown();
        t_query();
        t_vpp();
        t_vcc();
        t_err_race();
        t_chip_erase();
        t_reset_again();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule